// File: doc/BRIEF.md
# MDIO management master controller

This block is the management-bus master that a host uses to reach the registers of external PHYs. The host writes a command (opcode, PHY address, register or device field) and, for transfers that carry data out, a 16-bit write value. The block serialises one frame on the management data line and produces the management clock from the system clock through a programmable divider. It then reports through pending flags and a read-data port with a validity flag.

A single configuration bit selects the frame family. With the bit clear, the short register format is used: a one-byte-ish header, a 5-bit register field and 16 data bits. With the bit set, the extended format is used, and the register field names the target device inside the PHY. Each register access in this format then takes two commands: an address frame that loads the 16-bit register number, followed by a write or read frame. The bidirectional line is modelled as a separate output value, an output enable and an input.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in flight, `mdc` is high, `mdio_oe` is low, both pending flags are low, and after reset `rd_valid` is 0 and `rd_data` is 0.
- R2: Each bit time is a low half followed by a high half of `mdc`, and each half lasts `cfg_div`+1 system clock cycles. The low half of the first bit begins on the clock edge that accepts the command. `mdio_out` changes only together with a falling `mdc`, and `mdio_in` is captured on the edge where `mdc` rises.
- R3: When `cfg_preamble` is 1 at acceptance, 32 bit times of driven 1 precede the frame; when it is 0, the frame starts at once.
- R4: With `cfg_clause45`=0 the 32 frame bits are sent MSB first: start 01, then the wire opcode, `cmd_phy`, `cmd_reg`, turnaround 10 and 16 data bits. The wire opcode is 01 (write) when `cmd_op[0]`=0 and 10 (read) when `cmd_op[0]`=1; `cmd_op[1]` is ignored.
- R5: With `cfg_clause45`=1 the start field is 00 and the wire opcode equals `cmd_op` (0 address, 1 write, 2 read with post-increment, 3 read). `cmd_reg` carries the device number, and for opcodes 0 and 1 the data field is the write value.
- R6: A read is `cmd_op[0]`=1 in the short format or `cmd_op[1]`=1 in the extended format. For a read, `mdio_oe` is low for the last 18 bit times (turnaround and data). The 16 data bits are captured MSB first, and `rd_data` changes only on the edge that ends a read frame.
- R7: `rd_valid` goes to 0 on the edge that accepts a read. On the edge that ends the read, it becomes 1 only if `mdio_in` was 0 when captured on the second turnaround bit.
- R8: `rd_pending` (reads) or `wr_pending` (writes and address frames) is high from the accepting edge until the edge that ends the frame, and never both at once.
- R9: `cmd_go` while a frame is in flight is ignored: the frame on the wire and the flags are unaffected and no later frame results.
- R10: The write value is taken from `wr_data` when `wr_load` is high in the same cycle as an accepted `cmd_go`, else from the last loaded value. A `wr_load` during a frame does not alter that frame but is used by later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_clause45 | input | 1 | Frame family: 0 short register format, 1 extended device format |
| cfg_preamble | input | 1 | Send the 32-bit all-ones preamble before a frame |
| cfg_div | input | DIV_W | Management clock half period minus one, in system cycles |
| cmd_go | input | 1 | Start a frame with the command fields (ignored while busy) |
| cmd_op | input | 2 | Operation code, interpreted per frame family |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register number (short format) or device number (extended) |
| wr_load | input | 1 | Load `wr_data` into the write-value register |
| wr_data | input | 16 | Write value or, for address frames, register number |
| wr_pending | output | 1 | A write or address frame is in flight |
| rd_pending | output | 1 | A read frame is in flight |
| rd_valid | output | 1 | Last read saw the PHY drive the second turnaround bit low |
| rd_data | output | 16 | Data of the last completed read |
| mdc | output | 1 | Management clock, idles high |
| mdio_out | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line value seen at the pin |

## Verification
Two host actions can land in one cycle: a write-value load and a frame start. The bench raises `wr_load` and `cmd_go` together and checks that the new value, not the stale one, appears in the data bits on the wire. It also issues a load and a second start while a frame is in flight. It checks that the current frame keeps its original bits and that no extra frame follows, and that the next accepted frame carries the value loaded during the busy period. A reference model predicts the bus, flags and read results for every clock and compares them each cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W  = 32;
   localparam int PRE_W    = 32;
   localparam int DATA_W   = 16;
   localparam int REL_FROM = 14;   // first released bit of a read frame
   localparam int TA_LOW   = 15;   // bit the PHY must drive low
   localparam int DATA_LO  = 16;   // first data bit position

   typedef enum logic [1:0] {
      WOP_ADDR  = 2'b00,
      WOP_WRITE = 2'b01,
      WOP_READ  = 2'b10
   } short_wop_e;

   function automatic logic op_is_read(input logic ext, input logic [1:0] op);
      return ext ? op[1] : op[0];
   endfunction

   function automatic logic [FRAME_W-1:0] make_frame(
      input logic ext, input logic [1:0] op, input logic [4:0] phy,
      input logic [4:0] regad, input logic [DATA_W-1:0] data);
      logic [1:0] st;
      logic [1:0] wop;
      short_wop_e sw;
      sw  = op[0] ? WOP_READ : WOP_WRITE;
      st  = ext ? 2'b00 : 2'b01;
      wop = ext ? op : sw;
      return {st, wop, phy, regad, 2'b10,
              op_is_read(ext, op) ? {DATA_W{1'b0}} : data};
   endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (!run || tick)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mdio_insync.sv
module mdio_insync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2 >= 0 ? STAGES-2 : 0:0], din};
         end
         assign dout = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
   import mdio_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic               rd_in,
   input  logic               pre_in,
   input  logic               tick,
   input  logic               sdi,
   output logic               active,
   output logic               mdc,
   output logic               sdo,
   output logic               sdo_en,
   output logic               fin,
   output logic               ta_ok,
   output logic [DATA_W-1:0]  rx
);
   localparam int POS_W = $clog2(PRE_W + FRAME_W);

   logic [POS_W-1:0]   pos;
   logic [POS_W-1:0]   jpos;
   logic [POS_W-1:0]   last_pos;
   logic [FRAME_W-1:0] frame_q;
   logic               rd_q;
   logic               pre_q;

   // {output enable, output value} for bit position p of the whole sequence
   function automatic logic [1:0] drive(input logic pre, input logic rd,
                                        input logic [FRAME_W-1:0] fr,
                                        input logic [POS_W-1:0] p);
      logic [POS_W-1:0] j;
      if (pre && p < POS_W'(PRE_W)) return 2'b11;
      j = pre ? p - POS_W'(PRE_W) : p;
      return {!(rd && j >= POS_W'(REL_FROM)), fr[5'(FRAME_W-1) - j[4:0]]};
   endfunction

   assign jpos     = pre_q ? pos - POS_W'(PRE_W) : pos;
   assign last_pos = pre_q ? POS_W'(PRE_W + FRAME_W - 1) : POS_W'(FRAME_W - 1);
   assign fin      = active && tick && mdc && (pos == last_pos);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         mdc     <= 1'b1;
         sdo     <= 1'b0;
         sdo_en  <= 1'b0;
         pos     <= '0;
         frame_q <= '0;
         rd_q    <= 1'b0;
         pre_q   <= 1'b0;
         ta_ok   <= 1'b0;
         rx      <= '0;
      end else if (start && !active) begin
         active        <= 1'b1;
         mdc           <= 1'b0;
         pos           <= '0;
         frame_q       <= frame_in;
         rd_q          <= rd_in;
         pre_q         <= pre_in;
         ta_ok         <= 1'b0;
         {sdo_en, sdo} <= drive(pre_in, rd_in, frame_in, '0);
      end else if (active && tick) begin
         if (!mdc) begin
            mdc <= 1'b1;
            if (rd_q && jpos == POS_W'(TA_LOW)) ta_ok <= !sdi;
            if (rd_q && jpos >= POS_W'(DATA_LO) && jpos < POS_W'(FRAME_W))
               rx <= {rx[DATA_W-2:0], sdi};
         end else if (fin) begin
            active <= 1'b0;
            sdo_en <= 1'b0;
         end else begin
            mdc           <= 1'b0;
            pos           <= pos + 1'b1;
            {sdo_en, sdo} <= drive(pre_q, rd_q, frame_q, pos + 1'b1);
         end
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_clause45,
   input  logic              cfg_preamble,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              cmd_go,
   input  logic [1:0]        cmd_op,
   input  logic [4:0]        cmd_phy,
   input  logic [4:0]        cmd_reg,
   input  logic              wr_load,
   input  logic [15:0]       wr_data,
   output logic              wr_pending,
   output logic              rd_pending,
   output logic              rd_valid,
   output logic [15:0]       rd_data,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("mdio_master: DIV_W must be 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("mdio_master: SYNC_STAGES must be 0..3");
      end
   endgenerate

   logic [DATA_W-1:0] wval_q;
   logic [DATA_W-1:0] wval_eff;
   logic              busy;
   logic              accept;
   logic              is_rd;
   logic              rd_kind_q;
   logic              tick;
   logic              sdi;
   logic              fin;
   logic              ta_ok;
   logic [DATA_W-1:0] rx;

   assign wval_eff = wr_load ? wr_data : wval_q;
   assign accept   = cmd_go && !busy;
   assign is_rd    = op_is_read(cfg_clause45, cmd_op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wval_q    <= '0;
         rd_kind_q <= 1'b0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         if (wr_load) wval_q <= wr_data;
         if (accept) rd_kind_q <= is_rd;
         if (accept && is_rd) begin
            rd_valid <= 1'b0;
         end else if (fin && rd_kind_q) begin
            rd_valid <= ta_ok;
            rd_data  <= rx;
         end
      end
   end

   assign rd_pending = busy && rd_kind_q;
   assign wr_pending = busy && !rd_kind_q;

   mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg_div), .tick(tick));

   mdio_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mdio_in), .dout(sdi));

   mdio_engine u_eng (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .frame_in(make_frame(cfg_clause45, cmd_op, cmd_phy, cmd_reg, wval_eff)),
      .rd_in(is_rd), .pre_in(cfg_preamble), .tick(tick), .sdi(sdi),
      .active(busy), .mdc(mdc), .sdo(mdio_out), .sdo_en(mdio_oe),
      .fin(fin), .ta_ok(ta_ok), .rx(rx));
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mdc,
   input logic        mdio_out,
   input logic        mdio_oe,
   input logic        rd_pending,
   input logic        wr_pending,
   input logic        rd_valid,
   input logic [15:0] rd_data
);
   // R2
   out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_out) |-> $fell(mdc));

   // R1
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_pending && !wr_pending) |-> (mdc && !mdio_oe));

   // R7
   valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $fell(rd_pending));

   // R7
   valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_pending) |-> !rd_valid);

   // R6
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pending && $past(rd_pending)) |-> $stable(rd_data));

   // R8
   one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_pending, wr_pending}));
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
   .mdio_oe(mdio_oe), .rd_pending(rd_pending), .wr_pending(wr_pending),
   .rd_valid(rd_valid), .rd_data(rd_data));

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_clause45 = 1'b0;
   logic        cfg_preamble = 1'b0;
   logic [7:0]  cfg_div = 8'd1;
   logic        cmd_go = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [4:0]  cmd_phy = 5'd0;
   logic [4:0]  cmd_reg = 5'd0;
   logic        wr_load = 1'b0;
   logic [15:0] wr_data = 16'd0;
   logic        wr_pending, rd_pending, rd_valid, mdc, mdio_out, mdio_oe;
   logic [15:0] rd_data;
   logic        mdio_in = 1'b1;

   always #4 clk = ~clk;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .cfg_clause45(cfg_clause45),
      .cfg_preamble(cfg_preamble), .cfg_div(cfg_div), .cmd_go(cmd_go),
      .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
      .wr_load(wr_load), .wr_data(wr_data), .wr_pending(wr_pending),
      .rd_pending(rd_pending), .rd_valid(rd_valid), .rd_data(rd_data),
      .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

   typedef struct packed {
      logic mdc, oe, out, pin, rdp, wrp, last, pre;
   } step_t;

   step_t       q[$];
   int          errors = 0;
   int          checks = 0;
   bit          finished = 0;
   logic        mv_valid = 1'b0;
   logic [15:0] mv_data = 16'd0;
   logic        end_valid;
   logic [15:0] end_data;
   bit          end_is_rd = 0;
   logic [15:0] m_wval = 16'd0;
   bit          cur_ext = 0;
   string       scen = "reset";

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
      end
   endtask

   // reference model comparison, each cycle away from the clock edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !finished) begin
         if (q.size() > 0) begin
            step_t s;
            s = q.pop_front();
            chk(mdc == s.mdc, "R2", 32'(mdc), 32'(s.mdc));
            chk(mdio_oe == s.oe, "R6", 32'(mdio_oe), 32'(s.oe));
            if (s.oe)
               chk(mdio_out == s.out, s.pre ? "R3" : (cur_ext ? "R5" : "R4"),
                   32'(mdio_out), 32'(s.out));
            chk({rd_pending, wr_pending} == {s.rdp, s.wrp}, "R8",
                32'({rd_pending, wr_pending}), 32'({s.rdp, s.wrp}));
            chk(rd_valid == mv_valid, "R7", 32'(rd_valid), 32'(mv_valid));
            chk(rd_data == mv_data, "R6", 32'(rd_data), 32'(mv_data));
            mdio_in = s.pin;
            if (s.last && end_is_rd) begin
               mv_valid = end_valid;
               mv_data  = end_data;
            end
         end else begin
            chk(mdc == 1'b1 && mdio_oe == 1'b0, "R1",
                32'({mdc, mdio_oe}), 32'b10);
            chk({rd_pending, wr_pending} == 2'b00, "R8",
                32'({rd_pending, wr_pending}), 32'd0);
            chk(rd_valid == mv_valid, "R7", 32'(rd_valid), 32'(mv_valid));
            chk(rd_data == mv_data, "R6", 32'(rd_data), 32'(mv_data));
            mdio_in = 1'b1;
         end
      end
   end

   task automatic issue(input bit ext, input bit pre, input int div,
                        input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] rg, input bit ld,
                        input logic [15:0] ldv, input bit ta_good,
                        input logic [15:0] pdat);
      logic bits[$];
      bit   rd;
      int   off;
      step_t s;
      @(negedge clk);
      cfg_clause45 = ext; cfg_preamble = pre; cfg_div = 8'(div);
      cmd_op = op; cmd_phy = phy; cmd_reg = rg;
      wr_load = ld; wr_data = ldv; cmd_go = 1'b1;
      if (ld) m_wval = ldv;
      rd  = ext ? op[1] : op[0];
      off = pre ? 32 : 0;
      if (pre) repeat (32) bits.push_back(1'b1);
      bits.push_back(1'b0); bits.push_back(!ext);
      if (ext) begin bits.push_back(op[1]); bits.push_back(op[0]); end
      else begin bits.push_back(op[0]); bits.push_back(!op[0]); end
      for (int i = 4; i >= 0; i--) bits.push_back(phy[i]);
      for (int i = 4; i >= 0; i--) bits.push_back(rg[i]);
      bits.push_back(1'b1); bits.push_back(1'b0);
      for (int i = 15; i >= 0; i--) bits.push_back(rd ? 1'b0 : m_wval[i]);
      for (int i = 0; i < bits.size(); i++) begin
         int j;
         j = i - off;
         s.out = bits[i];
         s.pre = (i < off);
         s.oe  = !(rd && j >= 14);
         s.rdp = rd;
         s.wrp = !rd;
         if (rd && j == 15)      s.pin = ta_good ? 1'b0 : 1'b1;
         else if (rd && j >= 16) s.pin = pdat[31 - j];
         else                    s.pin = 1'b1;
         for (int k = 0; k < 2 * (div + 1); k++) begin
            s.mdc  = (k > div);
            s.last = (i == bits.size() - 1) && (k == 2 * div + 1);
            q.push_back(s);
         end
      end
      cur_ext = ext;
      end_is_rd = rd;
      if (rd) begin
         mv_valid  = 1'b0;
         end_valid = ta_good;
         end_data  = pdat;
      end
      @(negedge clk);
      cmd_go = 1'b0; wr_load = 1'b0;
   endtask

   task automatic wait_idle();
      while (q.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // start or load attempt while a frame is in flight
   task automatic poke(input bit go, input bit ld, input logic [15:0] v);
      @(negedge clk);
      cmd_op = 2'd3; cmd_phy = 5'h1F; cmd_reg = 5'h1F;
      cmd_go = go; wr_load = ld; wr_data = v;
      if (ld) m_wval = v;
      @(negedge clk);
      cmd_go = 1'b0; wr_load = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(mdc == 1'b1 && mdio_oe == 1'b0 && !rd_pending && !wr_pending,
          "R1", 32'({mdc, mdio_oe, rd_pending, wr_pending}), 32'b1000);
      chk(rd_valid == 1'b0 && rd_data == 16'd0, "R1",
          32'({rd_valid, rd_data}), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      scen = "R4 short write, load with start (R10)";
      issue(0, 0, 1, 2'd0, 5'h11, 5'h0A, 1, 16'hA55A, 0, 16'h0);
      wait_idle();
      scen = "R3 preamble short read good (R6 R7)";
      issue(0, 1, 2, 2'd1, 5'h05, 5'h02, 0, 16'h0, 1, 16'hC3E1);
      wait_idle();
      scen = "R7 short read undriven turnaround";
      issue(0, 0, 1, 2'd1, 5'h1F, 5'h1F, 0, 16'h0, 0, 16'h7E5A);
      wait_idle();
      scen = "R5 extended address frame";
      issue(1, 1, 1, 2'd0, 5'h03, 5'h03, 1, 16'h1234, 0, 16'h0);
      wait_idle();
      scen = "R5 extended read";
      issue(1, 0, 0, 2'd3, 5'h03, 5'h03, 0, 16'h0, 1, 16'h8001);
      wait_idle();
      scen = "R9 start and R10 load while busy";
      issue(1, 0, 2, 2'd1, 5'h0C, 5'h01, 1, 16'hBEEF, 0, 16'h0);
      repeat (10) @(negedge clk);
      poke(1, 0, 16'h0);
      repeat (10) @(negedge clk);
      poke(0, 1, 16'h0F0F);
      wait_idle();
      scen = "R5 extended read with increment";
      issue(1, 0, 1, 2'd2, 5'h0C, 5'h01, 0, 16'h0, 1, 16'h55AA);
      wait_idle();
      scen = "R10 later write uses value loaded while busy";
      issue(1, 0, 1, 2'd1, 5'h0C, 5'h01, 0, 16'h0, 0, 16'h0);
      wait_idle();
      scen = "R4 short format ignores op bit1 (write)";
      issue(0, 0, 0, 2'd2, 5'h00, 5'h10, 1, 16'h8421, 0, 16'h0);
      wait_idle();
      scen = "R4 short format ignores op bit1 (read)";
      issue(0, 1, 3, 2'd3, 5'h15, 5'h0E, 0, 16'h0, 1, 16'hFFFF);
      wait_idle();
      scen = "R7 read failure after good read";
      issue(1, 1, 0, 2'd3, 5'h02, 5'h1E, 0, 16'h0, 0, 16'h0);
      wait_idle();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog [%s] actual=timeout expected=completion", scen);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule